// File: doc/BRIEF.md
# Mid-Level Cache Line Coherence Controller

This block is the coherence engine for one line of a middle-level cache. The line sits between a private inner cache and a shared outer cache that keeps a directory. The controller takes one decoded event per cycle. An event can come from the inner cache (load, store, writeback, invalidation acknowledge), from the outer level (invalidate, forwarded shared or exclusive request, data, acknowledge, writeback acknowledge), or from a local replacement trigger. For each event the controller picks the next line state and raises a set of message strobes toward the inner and outer levels.

Each stable state exists in two forms: one where the inner cache also holds the line and one where it does not. Outer traffic that reaches a line the inner cache still holds is not served straight away. The controller first sends a purge command inward. It then parks the line in a purge-pending state and refuses the event, so that the sender retries after the inner cache answers. A small transaction record holds the line address, the data, a dirty bit and the running acknowledge balance. This record lets the controller answer for the data while an eviction is in flight, and lets it complete an exclusive request only once the data and every invalidation acknowledge have arrived.

Top module: `midcache_line_ctrl`

## Requirements
- R1: After reset, `line_state_o` is 0 (idle), `cmd_o` is all zero and `line_dirty_o` is 0. State codes: 0 idle, 1 shared+inner, 2 shared, 3 exclusive+inner, 4 exclusive, 5 modified+inner, 6 modified, 7 wait-shared, 8 wait-exclusive, 9 wait-upgrade, 10 wait-shared-killed, 11 evicting, 12 draining, 13 to 17 purge-pending from shared, exclusive, modified, modified-with-writeback and wait-upgrade.
- R2: Event codes: 0 load, 1 store, 2 inner writeback, 3 inner ack, 4 invalidate, 5 forward-exclusive, 6 forward-shared, 7 data, 8 exclusive data, 9 ack, 10 writeback ack, 11 replace. `cmd_o` bits: 0 read-shared, 1 read-exclusive, 2 upgrade, 3 evict, 4 data to requester, 5 data to home, 6 invalidate ack, 7 unblock, 8 exclusive unblock, 9 fill, 10 exclusive fill, 11 stale fill, 12 inner purge. A load in idle raises bit 0 and enters 7. A store in idle raises bit 1 and enters 8. A store in 1 or 2 raises bit 2 and enters 9. Every command and state change appears on the clock edge that accepts the event.
- R3: A load, store or replace in any of states 7 to 17 is stalled. `ev_ready` is low, and the next cycle shows no command and an unchanged state.
- R4: In 4 or 6, a forward-exclusive raises bit 4 and enters 0. A forward-shared raises bits 4 and 5 and enters 2.
- R5: A replace in 4 or 6 raises bit 3, with `cmd_dirty_o` equal to the dirty bit and `cmd_data_o` the line data, and enters 11. A writeback ack in 11 returns to 0 with the dirty bit cleared.
- R6: In 11, an invalidate raises bit 5, a forward-exclusive raises bit 4 and a forward-shared raises bits 4 and 5, each carrying the held data and entering 12. A writeback ack in 12 enters 0.
- R7: An invalidate in 7 raises bit 6 and enters 10. Data arriving in 10 raises bit 11 with that data and enters 0.
- R8: Exclusive data in 7 or 10 raises bits 10 and 8 and enters 3. Data in 7 raises bit 9 and enters 1, and also raises bit 7 when `ev_peer` is high.
- R9: An invalidate, forward or replace in 1, 3, 5, or an invalidate or forward in 9, raises bit 12 and enters 13, 14, 15 or 17 respectively, with `ev_ready` low.
- R10: An inner ack moves 13 to 2, 14 to 4, 15 and 16 to 6, and 17 to 8. An inner writeback in 14 or 15 enters 16. A dirty inner ack or writeback stores its data and sets the dirty bit.
- R11: In 8 or 9, each ack lowers the balance by one and data raises it by `ev_acks`. When data has arrived and the balance reaches zero, bits 10 and 8 rise and the line enters 5. Data whose count is not yet covered enters or stays in 9.
- R12: A load in 1 or 2 raises bit 9 and enters 1. A load in 4 raises bit 10 and enters 3. A load or store in 6 and a store in 4 raise bit 10 and enter 5.
- R13: An inner writeback in 3 or 5 enters 6. If `ev_dirty` is high it stores `ev_data` and sets the dirty bit; a clean writeback keeps the dirty bit unchanged.
- R14: An invalidate in 0 or 2 raises bit 6 and enters 0. In 6 it raises bit 5, carrying the data with its dirty flag, and enters 0 with the dirty bit cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_kind | input | 4 | Event code (R2) |
| ev_addr | input | AW | Line address carried by the event |
| ev_data | input | DW | Data carried by data or inner writeback events |
| ev_dirty | input | 1 | Inner data is modified |
| ev_peer | input | 1 | Data comes from a peer cache, not the home |
| ev_acks | input | CW | Acknowledges still owed, carried by data |
| ev_ready | output | 1 | Event consumed this cycle; low means retry |
| cmd_o | output | 13 | Message strobes, valid for one cycle (R2) |
| cmd_addr_o | output | AW | Address of the commands |
| cmd_data_o | output | DW | Data payload of the commands |
| cmd_dirty_o | output | 1 | Dirty flag of the payload |
| line_state_o | output | 5 | Current line state (R1) |
| line_dirty_o | output | 1 | Dirty bit of the line |

## Verification
The hardest case to reach is the purge-pending path. An outer request must arrive while the inner cache still holds the line. It must be refused, and it must be retried once the inner cache has answered, sometimes with a writeback in between. The stimulus first brings the line to an inner-held exclusive or modified state through a fill. It then sends an invalidate or forward, then an inner writeback and an inner ack, and finally replays the same outer request. A second hard case is acknowledges that arrive before the data that announces how many are owed. The stimulus sends an ack before data whose count leaves one ack still owed, and checks that the line completes only on the last ack.

// File: rtl/mlc_pkg.sv
package mlc_pkg;

   localparam int EV_W  = 4;
   localparam int ST_W  = 5;
   localparam int CMD_W = 13;

   typedef enum logic [ST_W-1:0] {
      ST_I        = 5'd0,
      ST_S_IN     = 5'd1,
      ST_S        = 5'd2,
      ST_E_IN     = 5'd3,
      ST_E        = 5'd4,
      ST_M_IN     = 5'd5,
      ST_M        = 5'd6,
      ST_WAIT_S   = 5'd7,
      ST_WAIT_X   = 5'd8,
      ST_WAIT_UP  = 5'd9,
      ST_WAIT_SK  = 5'd10,
      ST_EVICT    = 5'd11,
      ST_DRAIN    = 5'd12,
      ST_S_PURGE  = 5'd13,
      ST_E_PURGE  = 5'd14,
      ST_M_PURGE  = 5'd15,
      ST_MW_PURGE = 5'd16,
      ST_UP_PURGE = 5'd17
   } line_st_e;

   typedef enum logic [EV_W-1:0] {
      EV_LOAD      = 4'd0,
      EV_STORE     = 4'd1,
      EV_INNER_WB  = 4'd2,
      EV_INNER_ACK = 4'd3,
      EV_INV       = 4'd4,
      EV_FWD_X     = 4'd5,
      EV_FWD_S     = 4'd6,
      EV_DATA      = 4'd7,
      EV_DATA_X    = 4'd8,
      EV_ACK       = 4'd9,
      EV_WB_ACK    = 4'd10,
      EV_REPL      = 4'd11
   } ev_e;

   localparam int C_RD_SHR     = 0;
   localparam int C_RD_EXCL    = 1;
   localparam int C_UPGR       = 2;
   localparam int C_EVICT      = 3;
   localparam int C_DATA_REQ   = 4;
   localparam int C_DATA_HOME  = 5;
   localparam int C_INV_ACK    = 6;
   localparam int C_UNBLK      = 7;
   localparam int C_UNBLK_X    = 8;
   localparam int C_FILL       = 9;
   localparam int C_FILL_X     = 10;
   localparam int C_FILL_STALE = 11;
   localparam int C_PURGE      = 12;

   typedef struct packed {
      logic alloc;
      logic clear;
      logic wr_fill;
      logic wr_inner;
      logic ack_dec;
      logic need_add;
      logic settle;
   } rec_op_t;

   function automatic logic st_busy(input logic [ST_W-1:0] s);
      return s >= ST_WAIT_S;
   endfunction

endpackage

// File: rtl/mlc_record.sv
module mlc_record
   import mlc_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 32,
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  rec_op_t       op,
   input  logic [AW-1:0] ev_addr,
   input  logic [DW-1:0] ev_data,
   input  logic          ev_dirty,
   input  logic [CW-1:0] ev_acks,
   output logic [AW-1:0] rec_addr,
   output logic [DW-1:0] rec_data,
   output logic          rec_dirty,
   output logic          done_on_data,
   output logic          done_on_ack
);
   localparam int PW = CW + 1;

   logic signed [PW-1:0] bal_q;
   logic                 have_q;
   logic signed [PW-1:0] need_s;

   assign need_s       = $signed({1'b0, ev_acks});
   assign done_on_data = (bal_q + need_s) == '0;
   assign done_on_ack  = have_q && (bal_q == PW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_addr  <= '0;
         rec_data  <= '0;
         rec_dirty <= 1'b0;
         bal_q     <= '0;
         have_q    <= 1'b0;
      end else if (op.clear) begin
         rec_data  <= '0;
         rec_dirty <= 1'b0;
         bal_q     <= '0;
         have_q    <= 1'b0;
      end else if (op.alloc) begin
         rec_addr  <= ev_addr;
         rec_data  <= '0;
         rec_dirty <= 1'b0;
         bal_q     <= '0;
         have_q    <= 1'b0;
      end else begin
         if (op.wr_fill) rec_data <= ev_data;
         if (op.wr_inner && ev_dirty) begin
            rec_data  <= ev_data;
            rec_dirty <= 1'b1;
         end
         if (op.settle) begin
            bal_q  <= '0;
            have_q <= 1'b0;
         end else if (op.ack_dec) begin
            bal_q <= bal_q - PW'(1);
         end else if (op.need_add) begin
            bal_q  <= bal_q + need_s;
            have_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/mlc_xition.sv
module mlc_xition
   import mlc_pkg::*;
(
   input  line_st_e         state,
   input  logic             ev_valid,
   input  logic [EV_W-1:0]  ev_kind,
   input  logic             ev_peer,
   input  logic             done_on_data,
   input  logic             done_on_ack,
   output line_st_e         nxt,
   output logic [CMD_W-1:0] cmd,
   output logic             accept,
   output rec_op_t          op
);
   ev_e k;
   assign k = ev_e'(ev_kind);

   always_comb begin
      nxt    = state;
      cmd    = '0;
      accept = 1'b0;
      op     = '0;
      if (ev_valid) begin
         case (state)
            ST_I: begin
               case (k)
                  EV_LOAD:  begin nxt = ST_WAIT_S; cmd[C_RD_SHR]  = 1'b1; op.alloc = 1'b1; accept = 1'b1; end
                  EV_STORE: begin nxt = ST_WAIT_X; cmd[C_RD_EXCL] = 1'b1; op.alloc = 1'b1; accept = 1'b1; end
                  EV_INV:   begin cmd[C_INV_ACK] = 1'b1; accept = 1'b1; end
                  default: ;
               endcase
            end
            ST_S_IN, ST_S: begin
               case (k)
                  EV_LOAD:  begin nxt = ST_S_IN;    cmd[C_FILL] = 1'b1; accept = 1'b1; end
                  EV_STORE: begin nxt = ST_WAIT_UP; cmd[C_UPGR] = 1'b1; accept = 1'b1; end
                  EV_INV, EV_FWD_X, EV_FWD_S, EV_REPL: begin
                     if (state == ST_S_IN) begin
                        nxt = ST_S_PURGE; cmd[C_PURGE] = 1'b1;
                     end else if (k == EV_INV) begin
                        nxt = ST_I; cmd[C_INV_ACK] = 1'b1; op.clear = 1'b1; accept = 1'b1;
                     end else if (k == EV_REPL) begin
                        nxt = ST_I; op.clear = 1'b1; accept = 1'b1;
                     end
                  end
                  default: ;
               endcase
            end
            ST_E_IN, ST_M_IN: begin
               case (k)
                  EV_INNER_WB: begin nxt = ST_M; op.wr_inner = 1'b1; accept = 1'b1; end
                  EV_INV, EV_FWD_X, EV_FWD_S, EV_REPL: begin
                     nxt = (state == ST_E_IN) ? ST_E_PURGE : ST_M_PURGE;
                     cmd[C_PURGE] = 1'b1;
                  end
                  default: ;
               endcase
            end
            ST_E, ST_M: begin
               accept = 1'b1;
               case (k)
                  EV_LOAD:  begin nxt = (state == ST_E) ? ST_E_IN : ST_M_IN; cmd[C_FILL_X] = 1'b1; end
                  EV_STORE: begin nxt = ST_M_IN; cmd[C_FILL_X] = 1'b1; end
                  EV_REPL:  begin nxt = ST_EVICT; cmd[C_EVICT] = 1'b1; end
                  EV_INV: begin
                     nxt = ST_I; op.clear = 1'b1;
                     if (state == ST_E) cmd[C_INV_ACK] = 1'b1;
                     else               cmd[C_DATA_HOME] = 1'b1;
                  end
                  EV_FWD_X: begin nxt = ST_I; cmd[C_DATA_REQ] = 1'b1; op.clear = 1'b1; end
                  EV_FWD_S: begin nxt = ST_S; cmd[C_DATA_REQ] = 1'b1; cmd[C_DATA_HOME] = 1'b1; end
                  default:  accept = 1'b0;
               endcase
            end
            ST_EVICT, ST_DRAIN: begin
               accept = 1'b1;
               case (k)
                  EV_WB_ACK: begin nxt = ST_I; op.clear = 1'b1; end
                  EV_INV:    begin nxt = ST_DRAIN; cmd[C_DATA_HOME] = 1'b1; end
                  EV_FWD_X:  begin nxt = ST_DRAIN; cmd[C_DATA_REQ]  = 1'b1; end
                  EV_FWD_S:  begin nxt = ST_DRAIN; cmd[C_DATA_REQ]  = 1'b1; cmd[C_DATA_HOME] = 1'b1; end
                  default:   accept = 1'b0;
               endcase
               if (state == ST_DRAIN && k != EV_WB_ACK) begin
                  nxt = state; cmd = '0; accept = 1'b0;
               end
            end
            ST_WAIT_S, ST_WAIT_SK: begin
               accept = 1'b1;
               case (k)
                  EV_INV: begin nxt = ST_WAIT_SK; cmd[C_INV_ACK] = 1'b1; end
                  EV_DATA: begin
                     op.wr_fill = 1'b1;
                     cmd[C_UNBLK] = ev_peer;
                     if (state == ST_WAIT_S) begin
                        nxt = ST_S_IN; cmd[C_FILL] = 1'b1;
                     end else begin
                        nxt = ST_I; cmd[C_FILL_STALE] = 1'b1; op.clear = 1'b1;
                     end
                  end
                  EV_DATA_X: begin
                     nxt = ST_E_IN; op.wr_fill = 1'b1;
                     cmd[C_FILL_X] = 1'b1; cmd[C_UNBLK_X] = 1'b1;
                  end
                  default: accept = 1'b0;
               endcase
            end
            ST_WAIT_X, ST_WAIT_UP: begin
               accept = 1'b1;
               case (k)
                  EV_INV: begin
                     if (state == ST_WAIT_X) begin
                        cmd[C_INV_ACK] = 1'b1;
                     end else begin
                        nxt = ST_UP_PURGE; cmd[C_PURGE] = 1'b1; accept = 1'b0;
                     end
                  end
                  EV_FWD_X, EV_FWD_S: begin
                     accept = 1'b0;
                     if (state == ST_WAIT_UP) begin
                        nxt = ST_UP_PURGE; cmd[C_PURGE] = 1'b1;
                     end
                  end
                  EV_DATA, EV_DATA_X: begin
                     op.wr_fill = 1'b1;
                     if (done_on_data) begin
                        nxt = ST_M_IN; op.settle = 1'b1;
                        cmd[C_FILL_X] = 1'b1; cmd[C_UNBLK_X] = 1'b1;
                     end else begin
                        nxt = ST_WAIT_UP; op.need_add = 1'b1;
                     end
                  end
                  EV_ACK: begin
                     if (done_on_ack) begin
                        nxt = ST_M_IN; op.settle = 1'b1;
                        cmd[C_FILL_X] = 1'b1; cmd[C_UNBLK_X] = 1'b1;
                     end else begin
                        op.ack_dec = 1'b1;
                     end
                  end
                  default: accept = 1'b0;
               endcase
            end
            ST_S_PURGE, ST_E_PURGE, ST_M_PURGE, ST_MW_PURGE, ST_UP_PURGE: begin
               if (k == EV_INNER_ACK) begin
                  accept = 1'b1; op.wr_inner = 1'b1;
                  case (state)
                     ST_S_PURGE:  nxt = ST_S;
                     ST_E_PURGE:  nxt = ST_E;
                     ST_UP_PURGE: nxt = ST_WAIT_X;
                     default:     nxt = ST_M;
                  endcase
               end else if (k == EV_INNER_WB &&
                            (state == ST_E_PURGE || state == ST_M_PURGE)) begin
                  accept = 1'b1; op.wr_inner = 1'b1; nxt = ST_MW_PURGE;
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/mlc_cmd_stage.sv
module mlc_cmd_stage
   import mlc_pkg::*;
#(
   parameter bit REG_CMD = 1'b1,
   parameter int AW      = 16,
   parameter int DW      = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CMD_W-1:0] cmd_i,
   input  logic [AW-1:0]    addr_i,
   input  logic [DW-1:0]    data_i,
   input  logic             dirty_i,
   output logic [CMD_W-1:0] cmd_o,
   output logic [AW-1:0]    addr_o,
   output logic [DW-1:0]    data_o,
   output logic             dirty_o
);
   if (REG_CMD) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cmd_o   <= '0;
            addr_o  <= '0;
            data_o  <= '0;
            dirty_o <= 1'b0;
         end else begin
            cmd_o   <= cmd_i;
            addr_o  <= addr_i;
            data_o  <= data_i;
            dirty_o <= dirty_i;
         end
      end
   end else begin : g_comb
      assign cmd_o   = cmd_i;
      assign addr_o  = addr_i;
      assign data_o  = data_i;
      assign dirty_o = dirty_i;
   end

endmodule

// File: rtl/midcache_line_ctrl.sv
module midcache_line_ctrl
   import mlc_pkg::*;
#(
   parameter int AW      = 16,
   parameter int DW      = 32,
   parameter int CW      = 4,
   parameter bit REG_CMD = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ev_valid,
   input  logic [EV_W-1:0]      ev_kind,
   input  logic [AW-1:0]        ev_addr,
   input  logic [DW-1:0]        ev_data,
   input  logic                 ev_dirty,
   input  logic                 ev_peer,
   input  logic [CW-1:0]        ev_acks,
   output logic                 ev_ready,
   output logic [CMD_W-1:0]     cmd_o,
   output logic [AW-1:0]        cmd_addr_o,
   output logic [DW-1:0]        cmd_data_o,
   output logic                 cmd_dirty_o,
   output logic [ST_W-1:0]      line_state_o,
   output logic                 line_dirty_o
);
   if (AW < 1) begin : g_bad_aw
      $error("midcache_line_ctrl: AW must be at least 1");
   end
   if (DW < 1) begin : g_bad_dw
      $error("midcache_line_ctrl: DW must be at least 1");
   end
   if (CW < 1 || CW > 16) begin : g_bad_cw
      $error("midcache_line_ctrl: CW must lie in 1..16");
   end

   line_st_e         state_q, state_d;
   logic [CMD_W-1:0] cmd_d;
   rec_op_t          op;
   logic [AW-1:0]    rec_addr;
   logic [DW-1:0]    rec_data;
   logic             rec_dirty;
   logic             done_on_data, done_on_ack;
   logic             data_ev;
   logic [AW-1:0]    pay_addr;
   logic [DW-1:0]    pay_data;

   mlc_xition u_xition (
      .state        (state_q),
      .ev_valid     (ev_valid),
      .ev_kind      (ev_kind),
      .ev_peer      (ev_peer),
      .done_on_data (done_on_data),
      .done_on_ack  (done_on_ack),
      .nxt          (state_d),
      .cmd          (cmd_d),
      .accept       (ev_ready),
      .op           (op)
   );

   mlc_record #(.AW(AW), .DW(DW), .CW(CW)) u_record (
      .clk          (clk),
      .rst_n        (rst_n),
      .op           (op),
      .ev_addr      (ev_addr),
      .ev_data      (ev_data),
      .ev_dirty     (ev_dirty),
      .ev_acks      (ev_acks),
      .rec_addr     (rec_addr),
      .rec_data     (rec_data),
      .rec_dirty    (rec_dirty),
      .done_on_data (done_on_data),
      .done_on_ack  (done_on_ack)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_I;
      else        state_q <= state_d;
   end

   assign data_ev  = (ev_kind == EV_DATA) || (ev_kind == EV_DATA_X);
   assign pay_data = data_ev ? ev_data : rec_data;
   assign pay_addr = (state_q == ST_I) ? ev_addr : rec_addr;

   mlc_cmd_stage #(.REG_CMD(REG_CMD), .AW(AW), .DW(DW)) u_cmd (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_i   (cmd_d),
      .addr_i  (pay_addr),
      .data_i  (pay_data),
      .dirty_i (rec_dirty),
      .cmd_o   (cmd_o),
      .addr_o  (cmd_addr_o),
      .data_o  (cmd_data_o),
      .dirty_o (cmd_dirty_o)
   );

   assign line_state_o = state_q;
   assign line_dirty_o = rec_dirty;

endmodule

// File: rtl/mlc_checker.sv
module mlc_checker
   import mlc_pkg::*;
#(
   parameter bit REG_CMD = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ev_valid,
   input logic [EV_W-1:0]  ev_kind,
   input logic             ev_ready,
   input logic [CMD_W-1:0] cmd_o,
   input logic             cmd_dirty_o,
   input logic [ST_W-1:0]  line_state_o,
   input logic             line_dirty_o
);
   logic core_ev, outer_req, inner_held;
   assign core_ev    = ev_valid && (ev_kind == EV_LOAD || ev_kind == EV_STORE || ev_kind == EV_REPL);
   assign outer_req  = ev_valid && (ev_kind == EV_INV || ev_kind == EV_FWD_X || ev_kind == EV_FWD_S);
   assign inner_held = (line_state_o == ST_S_IN) || (line_state_o == ST_E_IN) || (line_state_o == ST_M_IN);

   p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (line_state_o == ST_I) && !line_dirty_o);

   p_stall_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
      core_ev && st_busy(line_state_o) |-> !ev_ready ##1 $stable(line_state_o));

   p_purge_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      outer_req && inner_held |-> !ev_ready);

   p_drain_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid && ev_kind == EV_WB_ACK && line_state_o == ST_DRAIN |=> line_state_o == ST_I);

   if (REG_CMD) begin : g_reg_props
      p_stall_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
         core_ev && st_busy(line_state_o) |=> cmd_o == '0);

      p_evict_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
         cmd_o[C_EVICT] |-> cmd_dirty_o == line_dirty_o);

      p_stale_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
         cmd_o[C_FILL_STALE] |-> line_state_o == ST_I);

      p_xfill_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
         cmd_o[C_FILL_X] && cmd_o[C_UNBLK_X] |-> (line_state_o == ST_E_IN) || (line_state_o == ST_M_IN));

      p_purge_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
         outer_req && inner_held |=> cmd_o[C_PURGE] && line_state_o >= ST_S_PURGE);
   end

endmodule

bind midcache_line_ctrl mlc_checker #(.REG_CMD(REG_CMD)) u_mlc_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .ev_valid     (ev_valid),
   .ev_kind      (ev_kind),
   .ev_ready     (ev_ready),
   .cmd_o        (cmd_o),
   .cmd_dirty_o  (cmd_dirty_o),
   .line_state_o (line_state_o),
   .line_dirty_o (line_dirty_o)
);

// File: tb/tb_midcache_line_ctrl.sv
module tb_midcache_line_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int CW = 4;

   // event codes (R2)
   localparam logic [3:0] K_LOAD = 4'd0, K_STORE = 4'd1, K_IWB = 4'd2, K_IACK = 4'd3,
                          K_INV = 4'd4, K_FWDX = 4'd5, K_FWDS = 4'd6, K_DATA = 4'd7,
                          K_DATAX = 4'd8, K_ACK = 4'd9, K_WBACK = 4'd10, K_REPL = 4'd11;
   // command masks (R2)
   localparam logic [12:0] M_RDS = 13'h1 << 0, M_RDX = 13'h1 << 1, M_UPG = 13'h1 << 2,
                           M_EVI = 13'h1 << 3, M_DREQ = 13'h1 << 4, M_DHOME = 13'h1 << 5,
                           M_IACK = 13'h1 << 6, M_UNB = 13'h1 << 7, M_UNBX = 13'h1 << 8,
                           M_FILL = 13'h1 << 9, M_FILLX = 13'h1 << 10, M_STALE = 13'h1 << 11,
                           M_PURGE = 13'h1 << 12;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ev_valid = 1'b0, ev_dirty = 1'b0, ev_peer = 1'b0;
   logic [3:0] ev_kind = '0;
   logic [AW-1:0] ev_addr = 16'h0040;
   logic [DW-1:0] ev_data = '0;
   logic [CW-1:0] ev_acks = '0;
   logic ev_ready, cmd_dirty_o, line_dirty_o;
   logic [12:0] cmd_o;
   logic [AW-1:0] cmd_addr_o;
   logic [DW-1:0] cmd_data_o;
   logic [4:0] line_state_o;

   int checks = 0, failures = 0;
   bit done = 1'b0;
   logic rdy_s;
   logic [12:0] cmd_s;
   logic [4:0] st_s;
   logic [31:0] dat_s;
   logic dty_s;

   always #(CLK_PERIOD/2) clk = ~clk;

   midcache_line_ctrl #(.AW(AW), .DW(DW), .CW(CW)) dut (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_addr(ev_addr),
      .ev_data(ev_data), .ev_dirty(ev_dirty), .ev_peer(ev_peer), .ev_acks(ev_acks),
      .ev_ready(ev_ready), .cmd_o(cmd_o), .cmd_addr_o(cmd_addr_o), .cmd_data_o(cmd_data_o),
      .cmd_dirty_o(cmd_dirty_o), .line_state_o(line_state_o), .line_dirty_o(line_dirty_o)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [3:0] k, input logic [31:0] d = 0, input logic dt = 0,
                       input logic pr = 0, input logic [3:0] n = 0);
      ev_kind = k; ev_data = d; ev_dirty = dt; ev_peer = pr; ev_acks = n; ev_valid = 1'b1;
      #1 rdy_s = ev_ready;
      @(posedge clk);
      #1;
      ev_valid = 1'b0;
      cmd_s = cmd_o; st_s = line_state_o; dat_s = cmd_data_o; dty_s = cmd_dirty_o;
   endtask

   task automatic expect_ev(input string tag, input logic [4:0] st, input logic [12:0] c, input logic r);
      chk(st_s == st, {tag, " state"}, 32'(st_s), 32'(st));
      chk(cmd_s == c, {tag, " cmd"}, 32'(cmd_s), 32'(c));
      chk(rdy_s == r, {tag, " ready"}, 32'(rdy_s), 32'(r));
   endtask

   task automatic do_reset();
      ev_valid = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      chk(line_state_o == 5'd0, "R1 state", 32'(line_state_o), 0);
      chk(cmd_o == '0, "R1 cmd", 32'(cmd_o), 0);
      chk(line_dirty_o == 1'b0, "R1 dirty", 32'(line_dirty_o), 0);
   endtask

   task automatic t_shared_upgrade();
      do_reset();
      send(K_LOAD);                         expect_ev("R2 load miss", 5'd7, M_RDS, 1);
      send(K_DATA, 32'hA5A5_0001, 0, 1);    expect_ev("R8 peer fill", 5'd1, M_FILL | M_UNB, 1);
      chk(dat_s == 32'hA5A5_0001, "R8 fill data", dat_s, 32'hA5A5_0001);
      send(K_LOAD);                         expect_ev("R12 shared hit", 5'd1, M_FILL, 1);
      chk(dat_s == 32'hA5A5_0001, "R12 hit data", dat_s, 32'hA5A5_0001);
      send(K_STORE);                        expect_ev("R2 upgrade", 5'd9, M_UPG, 1);
      send(K_LOAD);                         expect_ev("R3 stall load", 5'd9, 13'h0, 0);
      send(K_ACK);                          expect_ev("R11 early ack", 5'd9, 13'h0, 1);
      send(K_DATA, 32'hA5A5_0002, 0, 0, 2); expect_ev("R11 data short", 5'd9, 13'h0, 1);
      send(K_ACK);                          expect_ev("R11 last ack", 5'd5, M_FILLX | M_UNBX, 1);
      chk(dat_s == 32'hA5A5_0002, "R11 grant data", dat_s, 32'hA5A5_0002);
   endtask

   task automatic t_inner_purge();
      send(K_IWB, 32'hA5A5_0003, 1);        expect_ev("R13 dirty wb", 5'd6, 13'h0, 1);
      chk(line_dirty_o == 1'b1, "R13 dirty set", 32'(line_dirty_o), 1);
      send(K_LOAD);                         expect_ev("R12 modified hit", 5'd5, M_FILLX, 1);
      chk(dat_s == 32'hA5A5_0003, "R12 modified data", dat_s, 32'hA5A5_0003);
      send(K_INV);                          expect_ev("R9 purge on inv", 5'd15, M_PURGE, 0);
      send(K_REPL);                         expect_ev("R3 stall repl", 5'd15, 13'h0, 0);
      send(K_IACK);                         expect_ev("R10 ack to M", 5'd6, 13'h0, 1);
      send(K_INV);                          expect_ev("R14 inv in M", 5'd0, M_DHOME, 1);
      chk(dat_s == 32'hA5A5_0003 && dty_s, "R14 inv data", dat_s, 32'hA5A5_0003);
      chk(line_dirty_o == 1'b0, "R14 dirty cleared", 32'(line_dirty_o), 0);
   endtask

   task automatic t_excl_forward();
      do_reset();
      send(K_LOAD);                         expect_ev("R2 load miss", 5'd7, M_RDS, 1);
      send(K_DATAX, 32'hA5A5_0004);         expect_ev("R8 excl fill", 5'd3, M_FILLX | M_UNBX, 1);
      send(K_FWDS);                         expect_ev("R9 purge on fwd", 5'd14, M_PURGE, 0);
      send(K_IWB, 32'hA5A5_0005, 1);        expect_ev("R10 wb in purge", 5'd16, 13'h0, 1);
      send(K_IACK);                         expect_ev("R10 ack to M", 5'd6, 13'h0, 1);
      send(K_FWDS);                         expect_ev("R4 fwd shared", 5'd2, M_DREQ | M_DHOME, 1);
      chk(dat_s == 32'hA5A5_0005, "R4 fwd data", dat_s, 32'hA5A5_0005);
      send(K_INV);                          expect_ev("R14 inv in shared", 5'd0, M_IACK, 1);
      send(K_INV);                          expect_ev("R14 inv in idle", 5'd0, M_IACK, 1);
   endtask

   task automatic t_evict();
      do_reset();
      send(K_LOAD);
      send(K_DATAX, 32'hA5A5_0006);         expect_ev("R8 excl fill", 5'd3, M_FILLX | M_UNBX, 1);
      send(K_REPL);                         expect_ev("R9 purge on repl", 5'd14, M_PURGE, 0);
      send(K_IACK);                         expect_ev("R10 ack to E", 5'd4, 13'h0, 1);
      send(K_REPL);                         expect_ev("R5 clean evict", 5'd11, M_EVI, 1);
      chk(dat_s == 32'hA5A5_0006 && !dty_s, "R5 clean evict payload", dat_s, 32'hA5A5_0006);
      send(K_FWDX);                         expect_ev("R6 fwd in evict", 5'd12, M_DREQ, 1);
      chk(dat_s == 32'hA5A5_0006, "R6 held data", dat_s, 32'hA5A5_0006);
      send(K_LOAD);                         expect_ev("R3 stall in drain", 5'd12, 13'h0, 0);
      send(K_WBACK);                        expect_ev("R6 drain done", 5'd0, 13'h0, 1);
      send(K_STORE);                        expect_ev("R2 store miss", 5'd8, M_RDX, 1);
      send(K_DATA, 32'hA5A5_0007, 0, 0, 0); expect_ev("R11 grant no acks", 5'd5, M_FILLX | M_UNBX, 1);
      send(K_IWB, 32'hA5A5_0008, 1);        expect_ev("R13 dirty wb", 5'd6, 13'h0, 1);
      send(K_REPL);                         expect_ev("R5 dirty evict", 5'd11, M_EVI, 1);
      chk(dat_s == 32'hA5A5_0008 && dty_s, "R5 dirty evict payload", dat_s, 32'hA5A5_0008);
      send(K_INV);                          expect_ev("R6 inv in evict", 5'd12, M_DHOME, 1);
      send(K_WBACK);                        expect_ev("R5 wb ack", 5'd0, 13'h0, 1);
      chk(line_dirty_o == 1'b0, "R5 dirty cleared", 32'(line_dirty_o), 0);
   endtask

   task automatic t_stale_and_home();
      do_reset();
      send(K_LOAD);
      send(K_INV);                          expect_ev("R7 inv in wait", 5'd10, M_IACK, 1);
      send(K_LOAD);                         expect_ev("R3 stall killed", 5'd10, 13'h0, 0);
      send(K_DATA, 32'hA5A5_0009);          expect_ev("R7 stale fill", 5'd0, M_STALE, 1);
      chk(dat_s == 32'hA5A5_0009, "R7 stale data", dat_s, 32'hA5A5_0009);
      send(K_LOAD);
      send(K_DATA, 32'hA5A5_000A);          expect_ev("R8 home fill", 5'd1, M_FILL, 1);
      send(K_STORE);                        expect_ev("R2 upgrade", 5'd9, M_UPG, 1);
      send(K_INV);                          expect_ev("R9 purge in upgrade", 5'd17, M_PURGE, 0);
      send(K_IACK);                         expect_ev("R10 ack to wait-x", 5'd8, 13'h0, 1);
      send(K_DATA, 32'hA5A5_000B);          expect_ev("R11 grant", 5'd5, M_FILLX | M_UNBX, 1);
      send(K_IWB, 32'hA5A5_000C, 0);        expect_ev("R13 clean wb", 5'd6, 13'h0, 1);
      chk(line_dirty_o == 1'b0, "R13 clean keeps dirty", 32'(line_dirty_o), 0);
      send(K_FWDX);                         expect_ev("R4 fwd excl", 5'd0, M_DREQ, 1);
      chk(dat_s == 32'hA5A5_000B, "R4 fwd excl data", dat_s, 32'hA5A5_000B);
   endtask

   initial begin
      t_reset();
      t_shared_upgrade();
      t_inner_purge();
      t_excl_forward();
      t_evict();
      t_stale_and_home();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule